// File: doc/BRIEF.md
# Circular OUT Endpoint Receive Buffer

This block takes the host-to-device data of one endpoint and lays it into a ring of 16-bit words held in a separate word-addressed memory. Incoming bytes arrive on a strobed byte stream framed by a start pulse and an end pulse. Each pair of bytes becomes one memory word. The first byte of the pair goes in the low half. The memory can only be written a whole word at a time.

The block owns the write offset of the ring. A downstream consumer owns the read offset and loads it through a register port once it has drained words. Packet data is written speculatively at a running pointer. When the end pulse arrives, the block answers ACK and commits the running pointer as the new write offset, but only if the running pointer never ran into the read offset. Otherwise it answers NAK, leaves the write offset where it was, and rewinds the running pointer so that the host's retry overwrites the same locations.

One ring slot is always kept empty, so equal offsets always mean an empty ring. The packet length is limited only by the free space. A byte presented in the same cycle as a start or end pulse is dropped.

Top module: `out_ep_rxbuf`

## Requirements
- R1: After reset, the write offset, read offset and fill level are all zero, and neither the handshake strobe nor the memory write strobe is high.
- R2: Within a packet, each even-numbered byte (counting from 0) forms the low half of a word and the following byte forms its high half. The memory write for that word is presented one cycle after the second byte is accepted.
- R3: If a packet has an odd byte count, its last byte is written as a word with 8'h00 in the high half. That write is presented one cycle after the end pulse.
- R4: Words of a packet go to consecutive ring addresses starting at the committed write offset. The address that follows DEPTH_WORDS-1 is 0.
- R5: A packet needing W words is accepted when W is at most DEPTH_WORDS-1 minus the fill level. Read offset changes made during the packet are taken into account. One cycle after the end pulse, hs_valid=1 and hs_ack=1, and in that same cycle wr_off has advanced by W modulo DEPTH_WORDS.
- R6: If storing a word would make the running pointer equal to the read offset, that word and every later word of the packet are not written. One cycle after the end pulse, hs_valid=1 and hs_ack=0, wr_off is unchanged, and the next packet starts writing at that unchanged offset.
- R7: There is no packet length limit other than free space. An empty ring accepts a packet of DEPTH_WORDS-1 words and refuses one of DEPTH_WORDS words.
- R8: A write on the read offset port shows on rd_off one cycle later. The collision check uses the new value from that cycle onward, and uses the old value in the cycle of the write itself.
- R9: fill_words equals (wr_off - rd_off) modulo DEPTH_WORDS at all times.
- R10: Bytes and end pulses that arrive outside a packet produce no memory write and no handshake, and do not move wr_off.
- R11: hs_valid is high for exactly one cycle per completed packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Pulse that opens a packet; it also aborts an unfinished packet |
| pkt_end | input | 1 | Pulse that closes the open packet |
| byte_valid | input | 1 | byte_data carries a packet byte this cycle |
| byte_data | input | 8 | Packet byte |
| mem_we | output | 1 | Word write strobe toward the buffer memory |
| mem_addr | output | AW | Word address of the write |
| mem_wdata | output | 16 | Word to write |
| hs_valid | output | 1 | Handshake decision is present (one cycle) |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK, meaningful while hs_valid is high |
| rd_off_we | input | 1 | Consumer loads a new read offset |
| rd_off_wdata | input | AW | New read offset, must be below DEPTH_WORDS |
| rd_off | output | AW | Current read offset |
| wr_off | output | AW | Committed write offset |
| fill_words | output | AW | Committed words waiting for the consumer |

## Verification
Each word's memory write appears one cycle after the byte or end pulse that completes it. The handshake and the new write offset appear one cycle after the end pulse. A read offset load shows one cycle after its strobe. The bench drives inputs on falling edges and samples the handshake, offsets and fill level at the falling edge right after the deciding rising edge. The memory writes are logged at every falling edge, and the log is compared one further falling edge later, so that the last write of a packet has certainly been captured. Expected addresses, words and decisions come from an arithmetic model of the ring that steps through the same cycles. That model also places any read offset change at the byte index where it takes effect.

// File: rtl/out_rxbuf_pkg.sv
package out_rxbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // receive framing state
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BODY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/orx_ring_inc.sv
// Ring successor: ptr + 1 with wrap after DEPTH-1.
module orx_ring_inc #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] ptr,
  output logic [AW-1:0] nxt
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  generate
    if (POW2) begin : g_pow2
      // natural binary wrap
      assign nxt = ptr + AW'(1);
    end else begin : g_cmp
      assign nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
    end
  endgenerate
endmodule

// File: rtl/orx_ring_level.sv
// Occupied words between a write and a read offset, modulo DEPTH.
module orx_ring_level #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] wr,
  input  logic [AW-1:0] rd,
  output logic [AW-1:0] level
);
  localparam logic [AW:0] SPAN = (AW + 1)'(DEPTH);

  logic [AW:0] wrapped;

  always_comb begin
    wrapped = {1'b0, wr} + SPAN - {1'b0, rd};
    if (wr >= rd) begin
      level = wr - rd;
    end else begin
      level = wrapped[AW-1:0];
    end
  end
endmodule

// File: rtl/orx_packer.sv
// Pairs bytes into little-endian 16-bit words; flush emits a held odd byte.
module orx_packer
  import out_rxbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  take,
  input  logic  flush,
  input  byte_t byte_in,
  output logic  fire,
  output word_t word
);
  logic  have_q, have_d;
  byte_t lo_q;
  logic  lo_en;

  always_comb begin
    have_d = have_q;
    fire   = 1'b0;
    word   = '0;
    lo_en  = 1'b0;
    if (clr) begin
      have_d = 1'b0;
    end else if (flush) begin
      fire   = have_q;
      word   = {8'h00, lo_q};
      have_d = 1'b0;
    end else if (take) begin
      if (have_q) begin
        fire   = 1'b1;
        word   = {byte_in, lo_q};
        have_d = 1'b0;
      end else begin
        lo_en  = 1'b1;
        have_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      have_q <= have_d;
      if (lo_en) begin
        lo_q <= byte_in;
      end
    end
  end
endmodule

// File: rtl/out_ep_rxbuf.sv
module out_ep_rxbuf
  import out_rxbuf_pkg::*;
#(
  parameter  int DEPTH_WORDS = 64,
  localparam int AW          = $clog2(DEPTH_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic          pkt_end,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          hs_valid,
  output logic          hs_ack,
  input  logic          rd_off_we,
  input  logic [AW-1:0] rd_off_wdata,
  output logic [AW-1:0] rd_off,
  output logic [AW-1:0] wr_off,
  output logic [AW-1:0] fill_words
);
  rx_state_e     state_q, state_d;
  logic [AW-1:0] run_q, run_d;
  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q;
  logic          coll_q, coll_d;
  logic          mem_we_q;
  logic [AW-1:0] mem_addr_q;
  word_t         mem_data_q;
  logic          hs_v_q, hs_v_d;
  logic          hs_a_q, hs_a_d;

  logic          in_body, take, end_ok;
  logic          fire;
  word_t         word;
  logic [AW-1:0] run_nxt, run_adv;
  logic          hit, wr_ok, new_coll, pkt_ok;

  assign in_body = (state_q == RX_BODY);
  // start wins over everything; a byte in a start or end cycle is dropped
  assign end_ok  = pkt_end & in_body & ~pkt_start;
  assign take    = byte_valid & in_body & ~pkt_start & ~pkt_end;

  orx_packer u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pkt_start),
    .take    (take),
    .flush   (end_ok),
    .byte_in (byte_data),
    .fire    (fire),
    .word    (word)
  );

  orx_ring_inc #(.DEPTH(DEPTH_WORDS), .AW(AW)) u_inc (
    .ptr (run_q),
    .nxt (run_nxt)
  );

  orx_ring_level #(.DEPTH(DEPTH_WORDS), .AW(AW)) u_level (
    .wr    (wr_q),
    .rd    (rd_q),
    .level (fill_words)
  );

  // a word may land only if the slot after it is not the read offset
  assign hit      = (run_nxt == rd_q);
  assign wr_ok    = fire & ~coll_q & ~hit;
  assign new_coll = fire & ~coll_q & hit;
  assign run_adv  = wr_ok ? run_nxt : run_q;
  assign pkt_ok   = ~(coll_q | new_coll);

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    wr_d    = wr_q;
    coll_d  = coll_q;
    hs_v_d  = 1'b0;
    hs_a_d  = 1'b0;
    if (pkt_start) begin
      state_d = RX_BODY;
      run_d   = wr_q;
      coll_d  = 1'b0;
    end else if (end_ok) begin
      state_d = RX_IDLE;
      hs_v_d  = 1'b1;
      hs_a_d  = pkt_ok;
      if (pkt_ok) begin
        wr_d  = run_adv;
        run_d = run_adv;
      end else begin
        run_d = wr_q;
      end
    end else begin
      if (wr_ok) begin
        run_d = run_nxt;
      end
      if (new_coll) begin
        coll_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      run_q   <= '0;
      wr_q    <= '0;
      coll_q  <= 1'b0;
      hs_v_q  <= 1'b0;
      hs_a_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      wr_q    <= wr_d;
      coll_q  <= coll_d;
      hs_v_q  <= hs_v_d;
      hs_a_q  <= hs_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_off_we) begin
      rd_q <= rd_off_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_q   <= 1'b0;
      mem_addr_q <= '0;
      mem_data_q <= '0;
    end else begin
      mem_we_q <= wr_ok;
      if (wr_ok) begin
        mem_addr_q <= run_q;
        mem_data_q <= word;
      end
    end
  end

  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_data_q;
  assign hs_valid  = hs_v_q;
  assign hs_ack    = hs_a_q;
  assign rd_off    = rd_q;
  assign wr_off    = wr_q;
endmodule

// File: rtl/orx_rxbuf_chk.sv
module orx_rxbuf_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_end,
  input logic          rd_off_we,
  input logic          hs_valid,
  input logic          hs_ack,
  input logic [AW-1:0] wr_off,
  input logic [AW-1:0] rd_off
);
  // R11: decision strobe never lasts two cycles
  p_hs_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  // R5: a decision always follows an end pulse
  p_hs_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(pkt_end));

  // R6: a refused packet leaves the committed offset alone
  p_nak_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ack) |-> $stable(wr_off));

  // R5: the committed offset moves only together with an ACK
  p_commit_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_off) |-> (hs_valid && hs_ack));

  // R8: the read offset changes only after a consumer load
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_off_we) |-> $stable(rd_off));
endmodule

bind out_ep_rxbuf orx_rxbuf_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_end   (pkt_end),
  .rd_off_we (rd_off_we),
  .hs_valid  (hs_valid),
  .hs_ack    (hs_ack),
  .wr_off    (wr_off),
  .rd_off    (rd_off)
);

// File: tb/test_out_ep_rxbuf.sv
module test_out_ep_rxbuf;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 6;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pkt_start, pkt_end, byte_valid;
  logic [7:0]    byte_data;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          hs_valid, hs_ack;
  logic          rd_off_we;
  logic [AW-1:0] rd_off_wdata;
  logic [AW-1:0] rd_off, wr_off, fill_words;

  out_ep_rxbuf #(.DEPTH_WORDS(D)) i_out_ep_rxbuf (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .byte_valid(byte_valid), .byte_data(byte_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .hs_valid(hs_valid),
    .hs_ack(hs_ack), .rd_off_we(rd_off_we), .rd_off_wdata(rd_off_wdata),
    .rd_off(rd_off), .wr_off(wr_off), .fill_words(fill_words)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int log_n = 0, hs_cnt = 0;
  int log_addr [16];
  int log_data [16];
  int m_wr = 0, m_rd = 0;
  bit last_ack;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int md(input int x);
    return ((x % D) + D) % D;
  endfunction

  // write and handshake log, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (log_n < 16) begin
          log_addr[log_n] = int'(mem_addr);
          log_data[log_n] = int'(mem_wdata);
        end
        log_n++;
      end
      if (hs_valid) hs_cnt++;
    end
  end

  task automatic set_rd(input int v);
    @(negedge clk);
    rd_off_we = 1'b1; rd_off_wdata = AW'(v);
    @(negedge clk);
    rd_off_we = 1'b0;
    m_rd = v;
    chk(int'(rd_off) == v, "R8 rd_off load", int'(rd_off), v);
    chk(int'(fill_words) == md(m_wr - m_rd), "R9 fill", int'(fill_words), md(m_wr - m_rd));
  endtask

  // upd_at: byte index during which the read offset is reloaded, -1 for none
  task automatic send_pkt(input int n, input int base, input int upd_at, input int upd_val);
    int e_addr [16];
    int e_data [16];
    int run, cnt, nw, rd_after, new_wr;
    bit coll, ack;
    run = m_wr; cnt = 0; coll = 0;
    nw = (n + 1) / 2;
    for (int k = 0; k < nw; k++) begin
      int c, rde, lo, hi;
      c   = (2*k + 1 < n) ? 2*k + 1 : n;
      rde = (upd_at >= 0 && upd_at < c) ? upd_val : m_rd;
      lo  = (base + 2*k) & 255;
      hi  = (2*k + 1 < n) ? ((base + 2*k + 1) & 255) : 0;
      if (!coll) begin
        if (md(run + 1) == rde) coll = 1;
        else begin
          e_addr[cnt] = run; e_data[cnt] = hi * 256 + lo;
          cnt++; run = md(run + 1);
        end
      end
    end
    ack      = !coll;
    new_wr   = ack ? run : m_wr;
    rd_after = (upd_at >= 0) ? upd_val : m_rd;

    @(negedge clk);
    log_n = 0;
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    for (int j = 0; j < n; j++) begin
      byte_valid = 1'b1; byte_data = 8'((base + j) & 255);
      rd_off_we = (j == upd_at); rd_off_wdata = AW'(upd_val);
      @(negedge clk);
    end
    byte_valid = 1'b0; rd_off_we = 1'b0; pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    last_ack = hs_ack;
    chk(hs_valid == 1'b1, "R5 hs_valid after end", int'(hs_valid), 1);
    chk(hs_ack == ack, ack ? "R5 ack" : "R6 nak", int'(hs_ack), int'(ack));
    chk(int'(wr_off) == new_wr, ack ? "R5 wr_off advance" : "R6 wr_off hold", int'(wr_off), new_wr);
    chk(int'(fill_words) == md(new_wr - rd_after), "R9 fill", int'(fill_words), md(new_wr - rd_after));
    @(negedge clk);
    chk(hs_valid == 1'b0, "R11 hs pulse width", int'(hs_valid), 0);
    chk(log_n == cnt, ack ? "R5 write count" : "R6 write count", log_n, cnt);
    for (int k = 0; k < cnt && k < log_n; k++) begin
      chk(log_addr[k] == e_addr[k], "R4 address", log_addr[k], e_addr[k]);
      chk(log_data[k] == e_data[k], (n % 2 == 1 && k == nw - 1) ? "R3 odd tail word" : "R2 word",
          log_data[k], e_data[k]);
    end
    m_wr = new_wr; m_rd = rd_after;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hs0;
    rst_n = 1'b0; pkt_start = 0; pkt_end = 0; byte_valid = 0; byte_data = '0;
    rd_off_we = 0; rd_off_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_off == '0, "R1 wr_off", int'(wr_off), 0);
    chk(rd_off == '0, "R1 rd_off", int'(rd_off), 0);
    chk(fill_words == '0, "R1 fill", int'(fill_words), 0);
    chk(hs_valid == 1'b0, "R1 hs_valid", int'(hs_valid), 0);
    chk(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);

    // R10: traffic outside a packet
    hs0 = hs_cnt; log_n = 0;
    for (int j = 0; j < 3; j++) begin
      byte_valid = 1'b1; byte_data = 8'(j + 1);
      @(negedge clk);
    end
    byte_valid = 1'b0; pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    repeat (3) @(negedge clk);
    chk(log_n == 0, "R10 no write", log_n, 0);
    chk(hs_cnt == hs0, "R10 no handshake", hs_cnt, hs0);
    chk(int'(wr_off) == m_wr, "R10 wr_off", int'(wr_off), m_wr);

    // sweep: every read offset against every packet length up to 2D+1 bytes
    for (int r = 0; r < D; r++) begin
      for (int n = 0; n <= 2*D + 1; n++) begin
        set_rd(r);
        send_pkt(n, r * 37 + n * 11, -1, 0);
      end
    end

    // R7: length bounded only by space
    set_rd(m_wr);
    send_pkt(2*(D-1), 200, -1, 0);
    chk(last_ack == 1'b1, "R7 full-size packet accepted", int'(last_ack), 1);
    set_rd(m_wr);
    send_pkt(2*D - 1, 90, -1, 0);
    chk(last_ack == 1'b0, "R7 one word too many refused", int'(last_ack), 0);

    // R8: read offset moved mid-packet, one cycle before vs same cycle as need
    set_rd(md(m_wr + 2));
    send_pkt(4, 60, 2, md(m_wr + 3));
    chk(last_ack == 1'b1, "R8 early move seen", int'(last_ack), 1);
    set_rd(md(m_wr + 2));
    send_pkt(4, 70, 3, md(m_wr + 3));
    chk(last_ack == 1'b0, "R8 same-cycle move not seen", int'(last_ack), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule